// File: doc/BRIEF.md
# SPI Host Interrupt Aggregator

This block gathers the error and event conditions of an SPI host controller into two level interrupt lines, one for errors and one for events. It owns a small set of control registers behind a single-cycle write port and a combinational read port: interrupt enable, interrupt state, interrupt test, error enable, error status, event enable and the chip-select index. Live controller status (ready, transmit queue empty, receive queue full) and single-cycle error pulses from the command and queue logic feed it.

Each line is evaluated every clock while its enable bit is set and its state bit is clear. A test bit outranks every real source, after which the sources are scanned in a fixed priority. Once raised, a state bit is sticky until software rewrites it. Chip-select index writes are range-checked against the configured number of chip selects; an out-of-range write is refused and flagged as an error.

Top module: `spi_irq_aggr`

## Requirements
- R1: After reset the error-enable register reads 0x1F, every other register reads 0, and both interrupt lines are low.
- R2: Register addresses are 0 interrupt state, 1 interrupt enable, 2 interrupt test, 3 error enable, 4 error status, 5 event enable, 6 chip-select index; address 7 reads 0. In the three interrupt registers bit 0 is the error line and bit 1 the event line, and each line output equals its interrupt-state bit, which a software write sets or clears directly.
- R3: Error status bits are 0 command-while-busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip-select index. With the error line enabled and its state clear, a status bit among 0, 3 and 4 that is set together with its error-enable bit raises the error line at the next clock edge.
- R4: The overflow and underflow status bits never raise the error line.
- R5: Event enable bits are 0 receive-full, 1 transmit-empty, 4 ready; bits 2 and 3 are not stored and read 0. With the event line enabled and its state clear, an enabled event whose status input is high raises the event line at the next clock edge.
- R6: A set test bit raises its line at the next clock edge when the line is enabled and its state is clear, with no real source present.
- R7: A line whose enable bit is clear never rises by itself, whatever its sources or test bit.
- R8: A set interrupt-state bit stays set until software writes it; after a clearing write, a source that is still present raises it again one cycle later.
- R9: A chip-select index write of a value at or above NUM_CS leaves the stored index unchanged and sets error status bit 4; a lower value is stored.
- R10: An error pulse sets its status bit at the next edge; status bits are cleared only by software writes, and a pulse wins over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for write and read |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| ready_i | input | 1 | Controller ready for a command |
| tx_empty_i | input | 1 | Transmit queue empty |
| rx_full_i | input | 1 | Receive queue full |
| cmd_busy_i | input | 1 | Pulse: command issued while busy |
| tx_overflow_i | input | 1 | Pulse: transmit queue overflow |
| rx_underflow_i | input | 1 | Pulse: receive queue underflow |
| cmd_inval_i | input | 1 | Pulse: invalid command |
| csid_o | output | CS_IDX_W | Stored chip-select index |
| irq_err_o | output | 1 | Error interrupt line |
| irq_evt_o | output | 1 | Event interrupt line |

## Verification
Assertions watch, on every cycle, that a raised state bit holds until a software write, that a disabled line cannot rise, that a test bit raises an enabled clear line, that the source picker grants at most one request, that a refused index leaves the stored index unchanged, and that an invalid-command pulse always lands in the status register. What only the bench scenarios show is the full cycle timing through two register stages (pulse to status to line), the register map and reset values, the masking of overflow and underflow, and the re-raise after a clearing write while a source persists. A bench reference model is compared against the lines, the stored index and the read data on every cycle of a long randomized run.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_ISTATE = 3'd0,
    A_IEN    = 3'd1,
    A_ITEST  = 3'd2,
    A_EEN    = 3'd3,
    A_ESTAT  = 3'd4,
    A_VEN    = 3'd5,
    A_CSID   = 3'd6
  } reg_idx_e;

  localparam int unsigned IRQ_W   = 2;
  localparam int unsigned IRQ_ERR = 0;
  localparam int unsigned IRQ_EVT = 1;

  localparam int unsigned ERR_W     = 5;
  localparam int unsigned E_BUSY    = 0;
  localparam int unsigned E_OVER    = 1;
  localparam int unsigned E_UNDER   = 2;
  localparam int unsigned E_CMDBAD  = 3;
  localparam int unsigned E_CSIDBAD = 4;
  localparam logic [ERR_W-1:0] EEN_RST = '1;

  // event enable bit positions as seen at the register
  localparam int unsigned V_RXFULL  = 0;
  localparam int unsigned V_TXEMPTY = 1;
  localparam int unsigned V_READY   = 4;
  localparam int unsigned VEN_W     = 3;

  localparam int unsigned N_ERR_SRC = 3;
  localparam int unsigned N_EVT_SRC = 3;
endpackage

// File: rtl/spi_irq_prio.sv
module spi_irq_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  // index 0 has the highest priority
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req_i[i];
    assign gnt_o[i]  = req_i[i] & ~seen[i];
  end
endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             test_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic             sw_we_i,
  input  logic             sw_val_i,
  output logic             state_o
);
  localparam int unsigned N_REQ = N_SRC + 1;

  logic [N_REQ-1:0] req, gnt;
  logic             state_q, fire;

  assign req = {src_i, test_i};

  spi_irq_prio #(.N(N_REQ)) u_prio (
    .req_i (req),
    .gnt_o (gnt)
  );

  assign fire = en_i & ~state_q & (|gnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else         state_q <= (sw_we_i ? sw_val_i : state_q) | fire;
  end

  assign state_o = state_q;

  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  // R8
  sticky_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q && !sw_we_i |=> state_q);

  // R7
  no_rise_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !sw_we_i && !state_q |=> !state_q);

  // R6
  test_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && test_i && !state_q |=> state_q);
endmodule

// File: rtl/spi_csid_guard.sv
module spi_csid_guard #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned VAL_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VAL_W-1:0] val_i,
  output logic [IDX_W-1:0] csid_o,
  output logic             bad_o
);
  logic [IDX_W-1:0] csid_q;
  logic             out_of_range;

  assign out_of_range = val_i >= VAL_W'(NUM_CS);
  assign bad_o        = we_i & out_of_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    csid_q <= '0;
    else if (we_i && !out_of_range) csid_q <= val_i[IDX_W-1:0];
  end

  assign csid_o = csid_q;

  // R9
  refused_keeps_csid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> $stable(csid_o));
endmodule

// File: rtl/spi_irq_aggr.sv
module spi_irq_aggr
  import spi_irq_pkg::*;
#(
  parameter int unsigned NUM_CS   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                ready_i,
  input  logic                tx_empty_i,
  input  logic                rx_full_i,
  input  logic                cmd_busy_i,
  input  logic                tx_overflow_i,
  input  logic                rx_underflow_i,
  input  logic                cmd_inval_i,
  output logic [CS_IDX_W-1:0] csid_o,
  output logic                irq_err_o,
  output logic                irq_evt_o
);
  logic [IRQ_W-1:0] ien_q, itest_q, istate;
  logic [ERR_W-1:0] een_q, est_q, est_set;
  logic [VEN_W-1:0] ven_q;
  logic             wr_istate, wr_ien, wr_itest, wr_een, wr_estat, wr_ven, wr_csid;
  logic             csid_bad;
  logic [N_ERR_SRC-1:0] err_src;
  logic [N_EVT_SRC-1:0] evt_src;

  assign wr_istate = reg_we_i && (reg_addr_i == A_ISTATE);
  assign wr_ien    = reg_we_i && (reg_addr_i == A_IEN);
  assign wr_itest  = reg_we_i && (reg_addr_i == A_ITEST);
  assign wr_een    = reg_we_i && (reg_addr_i == A_EEN);
  assign wr_estat  = reg_we_i && (reg_addr_i == A_ESTAT);
  assign wr_ven    = reg_we_i && (reg_addr_i == A_VEN);
  assign wr_csid   = reg_we_i && (reg_addr_i == A_CSID);

  spi_csid_guard #(
    .NUM_CS (NUM_CS),
    .IDX_W  (CS_IDX_W),
    .VAL_W  (DATA_W)
  ) u_csid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_csid),
    .val_i  (reg_wdata_i),
    .csid_o (csid_o),
    .bad_o  (csid_bad)
  );

  always_comb begin
    est_set            = '0;
    est_set[E_BUSY]    = cmd_busy_i;
    est_set[E_OVER]    = tx_overflow_i;
    est_set[E_UNDER]   = rx_underflow_i;
    est_set[E_CMDBAD]  = cmd_inval_i;
    est_set[E_CSIDBAD] = csid_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q   <= '0;
      itest_q <= '0;
      een_q   <= EEN_RST;
      est_q   <= '0;
      ven_q   <= '0;
    end else begin
      if (wr_ien)   ien_q   <= reg_wdata_i[IRQ_W-1:0];
      if (wr_itest) itest_q <= reg_wdata_i[IRQ_W-1:0];
      if (wr_een)   een_q   <= reg_wdata_i[ERR_W-1:0];
      if (wr_ven)   ven_q   <= {reg_wdata_i[V_READY], reg_wdata_i[V_TXEMPTY],
                                reg_wdata_i[V_RXFULL]};
      // hardware set wins over a software write
      est_q <= (wr_estat ? reg_wdata_i[ERR_W-1:0] : est_q) | est_set;
    end
  end

  // priority order: index 0 first
  assign err_src = {een_q[E_CSIDBAD] & est_q[E_CSIDBAD],
                    een_q[E_CMDBAD]  & est_q[E_CMDBAD],
                    een_q[E_BUSY]    & est_q[E_BUSY]};
  assign evt_src = {ven_q[0] & rx_full_i,
                    ven_q[1] & tx_empty_i,
                    ven_q[2] & ready_i};

  spi_irq_line #(.N_SRC(N_ERR_SRC)) u_err_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ien_q[IRQ_ERR]),
    .test_i   (itest_q[IRQ_ERR]),
    .src_i    (err_src),
    .sw_we_i  (wr_istate),
    .sw_val_i (reg_wdata_i[IRQ_ERR]),
    .state_o  (istate[IRQ_ERR])
  );

  spi_irq_line #(.N_SRC(N_EVT_SRC)) u_evt_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ien_q[IRQ_EVT]),
    .test_i   (itest_q[IRQ_EVT]),
    .src_i    (evt_src),
    .sw_we_i  (wr_istate),
    .sw_val_i (reg_wdata_i[IRQ_EVT]),
    .state_o  (istate[IRQ_EVT])
  );

  assign irq_err_o = istate[IRQ_ERR];
  assign irq_evt_o = istate[IRQ_EVT];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_ISTATE: reg_rdata_o[IRQ_W-1:0] = istate;
      A_IEN:    reg_rdata_o[IRQ_W-1:0] = ien_q;
      A_ITEST:  reg_rdata_o[IRQ_W-1:0] = itest_q;
      A_EEN:    reg_rdata_o[ERR_W-1:0] = een_q;
      A_ESTAT:  reg_rdata_o[ERR_W-1:0] = est_q;
      A_VEN: begin
        reg_rdata_o[V_RXFULL]  = ven_q[0];
        reg_rdata_o[V_TXEMPTY] = ven_q[1];
        reg_rdata_o[V_READY]   = ven_q[2];
      end
      A_CSID:   reg_rdata_o[CS_IDX_W-1:0] = csid_o;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R10
  pulse_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_inval_i |=> est_q[E_CMDBAD]);

  // R4
  masked_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_err_o && !wr_istate && !itest_q[IRQ_ERR] &&
    ((een_q & est_q & 5'b11001) == '0) |=> !irq_err_o);
endmodule

// File: tb/spi_irq_aggr_bench.sv
module spi_irq_aggr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ready_i = 1'b0, tx_empty_i = 1'b0, rx_full_i = 1'b0;
  logic        cmd_busy_i = 1'b0, tx_overflow_i = 1'b0;
  logic        rx_underflow_i = 1'b0, cmd_inval_i = 1'b0;
  logic [1:0]  csid_o;
  logic        irq_err_o, irq_evt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [1:0] m_is, m_ie, m_it;
  logic [4:0] m_ee, m_es;
  logic [2:0] m_ve;   // {ready, txempty, rxfull}
  logic [1:0] m_cs;

  spi_irq_aggr #(.NUM_CS(NCS), .DATA_W(32)) u_spi_irq_aggr (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .ready_i, .tx_empty_i, .rx_full_i, .cmd_busy_i, .tx_overflow_i,
    .rx_underflow_i, .cmd_inval_i, .csid_o, .irq_err_o, .irq_evt_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_is};
      3'd1: return {30'd0, m_ie};
      3'd2: return {30'd0, m_it};
      3'd3: return {27'd0, m_ee};
      3'd4: return {27'd0, m_es};
      3'd5: return {27'd0, m_ve[2], 2'b00, m_ve[1], m_ve[0]};
      3'd6: return {30'd0, m_cs};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [1:0] m_fire(input logic [2:0] st);
    logic e_src, v_src;
    e_src = m_it[0] | (|(m_ee & m_es & 5'b11001));
    v_src = m_it[1] | (m_ve[2] & st[2]) | (m_ve[1] & st[1]) | (m_ve[0] & st[0]);
    return {m_ie[1] & ~m_is[1] & v_src, m_ie[0] & ~m_is[0] & e_src};
  endfunction

  task automatic m_reset();
    m_is = '0; m_ie = '0; m_it = '0; m_ee = 5'h1F; m_es = '0; m_ve = '0; m_cs = '0;
  endtask

  // st = {ready, txempty, rxfull}; pl = {inval, underflow, overflow, busy}
  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic [2:0] st, input logic [3:0] pl);
    logic [1:0] f;
    logic       bad;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    {ready_i, tx_empty_i, rx_full_i} = st;
    {cmd_inval_i, rx_underflow_i, tx_overflow_i, cmd_busy_i} = pl;
    @(negedge clk_i);
    f   = m_fire(st);
    bad = we && a == 3'd6 && d >= NCS;
    m_is = ((we && a == 3'd0) ? d[1:0] : m_is) | f;
    m_es = ((we && a == 3'd4) ? d[4:0] : m_es) | {bad, pl};
    if (we && a == 3'd1) m_ie = d[1:0];
    if (we && a == 3'd2) m_it = d[1:0];
    if (we && a == 3'd3) m_ee = d[4:0];
    if (we && a == 3'd5) m_ve = {d[4], d[1], d[0]};
    if (we && a == 3'd6 && !bad) m_cs = d[1:0];
    chk({31'd0, irq_err_o}, {31'd0, m_is[0]}, "R3 error line");
    chk({31'd0, irq_evt_o}, {31'd0, m_is[1]}, "R5 event line");
    chk(reg_rdata_o, m_read(a), "R2 read data");
    chk({30'd0, csid_o}, {30'd0, m_cs}, "R9 index");
  endtask

  task automatic idle(); cyc(1'b0, 3'd7, 32'd0, 3'b000, 4'b0000); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      cyc(1'b0, 3'(a), 32'd0, 3'b000, 4'b0000);
      chk(reg_rdata_o, (a == 3) ? 32'h1F : 32'h0, "R1 reset register");
    end
    chk({30'd0, irq_evt_o, irq_err_o}, 32'd0, "R1 lines low");

    // R9 index range check
    cyc(1'b1, 3'd6, 32'd2, 3'b000, 4'b0000);
    chk(reg_rdata_o, 32'd2, "R9 valid index stored");
    cyc(1'b1, 3'd6, 32'd4, 3'b000, 4'b0000);
    chk(reg_rdata_o, 32'd2, "R9 refused index");
    cyc(1'b0, 3'd4, 32'd0, 3'b000, 4'b0000);
    chk({31'd0, reg_rdata_o[4]}, 32'd1, "R9 invalid index flagged");
    idle();
    chk({31'd0, irq_err_o}, 32'd0, "R7 disabled error line");

    // R10 set wins over clearing write
    cyc(1'b1, 3'd4, 32'd0, 3'b000, 4'b0001);
    chk(reg_rdata_o, 32'd1, "R10 set wins");
    cyc(1'b1, 3'd4, 32'd0, 3'b000, 4'b0000);
    chk(reg_rdata_o, 32'd0, "R10 cleared by write");

    // R4 overflow/underflow masked
    cyc(1'b1, 3'd1, 32'd3, 3'b000, 4'b0000);
    cyc(1'b0, 3'd4, 32'd0, 3'b000, 4'b0110);
    chk(reg_rdata_o, 32'h6, "R4 status bits set");
    idle(); idle();
    chk({31'd0, irq_err_o}, 32'd0, "R4 no error line");

    // R3 invalid command raises
    cyc(1'b0, 3'd0, 32'd0, 3'b000, 4'b1000);
    chk({31'd0, irq_err_o}, 32'd0, "R3 one cycle latency");
    cyc(1'b0, 3'd0, 32'd0, 3'b000, 4'b0000);
    chk({31'd0, irq_err_o}, 32'd1, "R3 error line raised");

    // R8 sticky and re-raise
    cyc(1'b1, 3'd0, 32'd0, 3'b000, 4'b0000);
    chk({31'd0, irq_err_o}, 32'd0, "R8 cleared by write");
    idle();
    chk({31'd0, irq_err_o}, 32'd1, "R8 re-raised");
    cyc(1'b1, 3'd4, 32'd0, 3'b000, 4'b0000);
    idle();
    chk({31'd0, irq_err_o}, 32'd1, "R8 sticky");
    cyc(1'b1, 3'd0, 32'd0, 3'b000, 4'b0000);
    idle();
    chk({31'd0, irq_err_o}, 32'd0, "R8 stays clear");

    // R5 events
    cyc(1'b1, 3'd5, 32'h10, 3'b000, 4'b0000);
    cyc(1'b0, 3'd0, 32'd0, 3'b100, 4'b0000);
    chk({31'd0, irq_evt_o}, 32'd1, "R5 ready event");
    cyc(1'b1, 3'd0, 32'd0, 3'b000, 4'b0000);
    idle();
    chk({31'd0, irq_evt_o}, 32'd0, "R5 event cleared");
    cyc(1'b1, 3'd5, 32'h1F, 3'b000, 4'b0000);
    chk(reg_rdata_o, 32'h13, "R5 unstored bits read 0");
    cyc(1'b0, 3'd0, 32'd0, 3'b010, 4'b0000);
    chk({31'd0, irq_evt_o}, 32'd1, "R5 txempty event");
    cyc(1'b1, 3'd0, 32'd0, 3'b000, 4'b0000);

    // R6 test bit
    cyc(1'b1, 3'd5, 32'd0, 3'b000, 4'b0000);
    cyc(1'b1, 3'd2, 32'd2, 3'b111, 4'b0000);
    idle();
    chk({31'd0, irq_evt_o}, 32'd1, "R6 test forces event");
    cyc(1'b1, 3'd2, 32'd0, 3'b000, 4'b0000);
    cyc(1'b1, 3'd0, 32'd0, 3'b000, 4'b0000);
    idle();
    chk({31'd0, irq_evt_o}, 32'd0, "R6 test released");

    // R7 disabled lines
    cyc(1'b1, 3'd1, 32'd0, 3'b000, 4'b0000);
    cyc(1'b1, 3'd2, 32'd3, 3'b111, 4'b1001);
    idle(); idle();
    chk({30'd0, irq_evt_o, irq_err_o}, 32'd0, "R7 no rise while disabled");
    cyc(1'b1, 3'd2, 32'd0, 3'b000, 4'b0000);
    cyc(1'b1, 3'd4, 32'd0, 3'b000, 4'b0000);

    // R2 direct state write
    cyc(1'b1, 3'd0, 32'd3, 3'b000, 4'b0000);
    chk({30'd0, irq_evt_o, irq_err_o}, 32'd3, "R2 state write drives lines");
    cyc(1'b1, 3'd0, 32'd0, 3'b000, 4'b0000);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      logic        we;
      logic [2:0]  a;
      logic [31:0] d;
      logic [3:0]  pl;
      we = ($urandom_range(0, 9) < 3);
      a  = 3'($urandom_range(0, 7));
      case (a)
        3'd0:    d = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 3)) : 32'd0;
        3'd2:    d = ($urandom_range(0, 4) == 0) ? 32'($urandom_range(0, 3)) : 32'd0;
        3'd6:    d = 32'($urandom_range(0, 7));
        default: d = $urandom();
      endcase
      pl = '0;
      for (int b = 0; b < 4; b++) pl[b] = ($urandom_range(0, 15) == 0);
      cyc(we, a, d, 3'($urandom_range(0, 7)), pl);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule